// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block cleans up to 32 general-purpose inputs before they reach edge and level interrupt detection. It sits after the input synchronizers. One programmable divider turns the peripheral clock into a sample tick that every pin shares. Each pin then has a small filter that moves its output only after the input has read the same value on two ticks in a row. Short glitches are removed, and slow, bouncy edges settle to one clean transition.

A per-pin select bit chooses what the interrupt logic sees. When the bit is set, it sees the filtered value. When the bit is clear, it sees the synchronized input straight through. Software programs two registers over a simple write strobe and a combinational read port: the filter select mask at offset 0x40 and the divider value at offset 0x44. Software works out the divider from the debounce time it wants and the clock rate.

Top module: `gpio_debounce_filter`

## Requirements
- R1: After reset, the select mask (offset 0x40) reads 0 and the divider register (offset 0x44) reads 0.
- R2: The divider register keeps bits 23:0 of a write. Bits 31:24 always read as zero.
- R3: The select mask register stores one bit per pin, with bit i belonging to pin i. It reads back what was last written.
- R4: A pin whose select bit is 0 drives its output from its synchronized input in the same cycle, with no register in between. The other pins' settings have no effect on it.
- R5: A pin whose select bit is 1 changes its output only on a sample tick where the input equals the value sampled on the previous tick. A pulse shorter than one tick period never reaches the output.
- R6: With a divider value P ≥ 2, a sample tick occurs once every P clock cycles. A value of 0 or 1 gives a tick on every cycle.
- R7: A write to the divider register restarts the period. The first tick comes P clock edges after the write edge and the second comes 2P edges after it. A filtered pin whose input changes at the write therefore updates on edge 2P.
- R8: A write to any other offset changes neither register, and a read from any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinSync | input | PIN_CNT | Synchronized pin levels |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset for both read and write |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr, combinational |
| pinOut | output | PIN_CNT | Levels passed on to interrupt detection |

## Verification
The assertions assume that pinSync already comes from synchronizers, so it changes only between clock edges. They also assume that a register write lasts exactly one cycle. The bench changes all inputs on the falling edge and pulses regWr for one cycle per write. The divider checks count edges from a write, so the bench changes the watched pin in the same cycle as the write. Before each measured sequence it lets the filter settle to a known level.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  // Strobes from the control side to the filter datapath
  typedef struct packed {
    logic sampleTick;
  } dbfStrobe_t;
endpackage

// File: rtl/dbf_ctrl.sv
module dbf_ctrl
  import dbf_pkg::*;
#(
  parameter int PIN_CNT = 32,
  parameter int PRESC_W = 24,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] DIV_OFS = 8'h44
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic [PIN_CNT-1:0] useFilt,
  output dbfStrobe_t         strobe
);
  localparam logic [PRESC_W-1:0] ONE = PRESC_W'(1);

  logic [PRESC_W-1:0] divVal;
  logic [PRESC_W-1:0] divCnt;
  logic [PRESC_W-1:0] effDiv;
  logic               maskHit;
  logic               divHit;
  logic               tickRaw;

  assign maskHit = regWr && (regAddr == MASK_OFS);
  assign divHit  = regWr && (regAddr == DIV_OFS);

  always_comb begin
    effDiv = (divVal <= ONE) ? ONE : divVal;
    // a divider write restarts the period, so no tick in that cycle
    tickRaw = !divHit && (divCnt >= effDiv - ONE);
    strobe.sampleTick = tickRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal  <= '0;
      useFilt <= '0;
      divCnt  <= '0;
    end else begin
      if (maskHit) useFilt <= regWdata[PIN_CNT-1:0];
      if (divHit)  divVal  <= regWdata[PRESC_W-1:0];
      if (divHit || tickRaw) divCnt <= '0;
      else                   divCnt <= divCnt + ONE;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == MASK_OFS)     regRdata[PIN_CNT-1:0] = useFilt;
    else if (regAddr == DIV_OFS) regRdata[PRESC_W-1:0] = divVal;
  end

  // R6: with a divider of two or more, ticks never land back to back
  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tickRaw && divVal > ONE) |=> (!tickRaw || divVal <= ONE));

  // R7: a divider write leaves the counter at the start of a period
  assert_reload_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    divHit |=> (divCnt == '0));

  // R8: a write elsewhere leaves both registers untouched
  assert_other_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr != MASK_OFS && regAddr != DIV_OFS) |=>
      ($stable(divVal) && $stable(useFilt)));
endmodule

// File: rtl/dbf_datapath.sv
module dbf_datapath
  import dbf_pkg::*;
#(
  parameter int PIN_CNT = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  dbfStrobe_t         strobe,
  input  logic [PIN_CNT-1:0] useFilt,
  input  logic [PIN_CNT-1:0] pinSync,
  output logic [PIN_CNT-1:0] pinOut
);
  logic [PIN_CNT-1:0] lastSample;
  logic [PIN_CNT-1:0] cleanLvl;

  for (genvar gi = 0; gi < PIN_CNT; gi++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lastSample[gi] <= 1'b0;
        cleanLvl[gi]   <= 1'b0;
      end else if (strobe.sampleTick) begin
        lastSample[gi] <= pinSync[gi];
        if (pinSync[gi] == lastSample[gi]) cleanLvl[gi] <= pinSync[gi];
      end
    end

    assign pinOut[gi] = useFilt[gi] ? cleanLvl[gi] : pinSync[gi];

    // R5: the clean level only moves on a tick
    assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.sampleTick |=> $stable(cleanLvl[gi]));

    // R5: a tick that disagrees with the previous sample cannot move it
    assert_need_two_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.sampleTick && pinSync[gi] != lastSample[gi]) |=> $stable(cleanLvl[gi]));
  end
endmodule

// File: rtl/gpio_debounce_filter.sv
module gpio_debounce_filter
  import dbf_pkg::*;
#(
  parameter int PIN_CNT = 32,
  parameter int PRESC_W = 24,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT-1:0] pinSync,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic [PIN_CNT-1:0] pinOut
);
  dbfStrobe_t         strobe;
  logic [PIN_CNT-1:0] useFilt;

  dbf_ctrl #(
    .PIN_CNT(PIN_CNT), .PRESC_W(PRESC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .useFilt(useFilt), .strobe(strobe)
  );

  dbf_datapath #(.PIN_CNT(PIN_CNT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .useFilt(useFilt),
    .pinSync(pinSync), .pinOut(pinOut)
  );

  // R2: the top byte of a divider read is always zero
  assert_div_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(8'h44)) |-> (regRdata[DATA_W-1:PRESC_W] == '0));
endmodule

// File: tb/sim_gpio_debounce_filter.sv
`timescale 1ns/1ps
module sim_gpio_debounce_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinSync = '0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] pinOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpio_debounce_filter u0 (
    .clk(clk), .rstN(rstN), .pinSync(pinSync), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .pinOut(pinOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // drive at a falling edge, one write cycle, return at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h40, v); chk("R1 mask reset", v, 32'h0);
    rd(8'h44, v); chk("R1 divider reset", v, 32'h0);
    pinSync = 32'hA5C3_0F1E; #1;
    chk("R4 raw pass after reset", pinOut, 32'hA5C3_0F1E);
    pinSync = '0;
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, v); chk("R2 upper divider bits zero", v, 32'h00FF_FFFF);
    wr(8'h40, 32'h1234_5678);
    rd(8'h40, v); chk("R3 mask readback", v, 32'h1234_5678);
    wr(8'h48, 32'hDEAD_BEEF);
    rd(8'h48, v); chk("R8 unmapped read zero", v, 32'h0);
    rd(8'h40, v); chk("R8 mask unchanged", v, 32'h1234_5678);
    rd(8'h44, v); chk("R8 divider unchanged", v, 32'h00FF_FFFF);
    wr(8'h40, 32'h0);
    wr(8'h44, 32'h0);
  endtask

  task automatic t_bypass();
    wr(8'h40, 32'h0000_0001);
    pinSync[5] = 1'b1; #1;
    chk("R4 unfiltered pin follows at once", {31'b0, pinOut[5]}, 32'h1);
    pinSync[5] = 1'b0; #1;
    chk("R4 unfiltered pin falls at once", {31'b0, pinOut[5]}, 32'h0);
    edges(4);
  endtask

  // pin0 filtered, settled low; raise it together with the divider write
  task automatic t_period(input int p, input string tag);
    int eff;
    eff = (p <= 1) ? 1 : p;
    wr(8'h44, 32'd3);
    edges(2);
    pinSync[0] = 1'b1;
    wr(8'h44, p);
    edges(2 * eff - 1);
    chk({tag, " still low one edge early"}, {31'b0, pinOut[0]}, 32'h0);
    edges(1);
    chk({tag, " high after two ticks"}, {31'b0, pinOut[0]}, 32'h1);
    pinSync[0] = 1'b0;
    edges(3 * eff + 2);
    chk({tag, " settles low again"}, {31'b0, pinOut[0]}, 32'h0);
  endtask

  task automatic t_glitch();
    bit seen = 0;
    wr(8'h44, 32'd4);
    edges(10);
    pinSync[0] = 1'b1;
    pinSync[2] = 1'b1; #1;
    chk("R4 other pin raw during glitch", {31'b0, pinOut[2]}, 32'h1);
    edges(2);
    pinSync[0] = 1'b0;
    pinSync[2] = 1'b0;
    for (int i = 0; i < 12; i++) begin
      edges(1);
      if (pinOut[0]) seen = 1;
    end
    chk("R5 short pulse rejected", {31'b0, seen}, 32'h0);
    pinSync[0] = 1'b1;
    edges(12);
    chk("R5 held level accepted", {31'b0, pinOut[0]}, 32'h1);
    pinSync[0] = 1'b0;
    edges(12);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_bypass();
    t_period(0, "R6 divider 0");
    t_period(1, "R6 divider 1");
    t_period(5, "R6 R7 divider 5");
    t_period(7, "R6 R7 divider 7");
    t_glitch();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule